// File: doc/BRIEF.md
# Descriptor Timestamp Seconds Rebuilder

When a frame is stamped, the DMA descriptor can hold only a small slice of the seconds count. It holds the nanoseconds and a few low seconds bits, and these are split across two 32-bit descriptor words. This block rebuilds the full time from that slice. It takes the two descriptor words together with the live seconds value of the running timer. The bits above the stored slice are filled in from the live timer. If the live timer has moved past a rollover of the slice since capture, the result is moved back by one slice period. The nanoseconds pass through unchanged.

A caller presents both words on a one-cycle strobe, together with the descriptor's stamp-present bit. The rebuilt time appears on the registered outputs on the next cycle, qualified by a valid pulse. The live seconds are sampled on the same edge as the words. Descriptors that carry no stamp produce no output.

Top module: `ts_sec_rebuild`

## Requirements
- R1: In the cycle after reset is held, `res_vld` is 0 and `res_sec` and `res_ns` are all zeros.
- R2: `res_ns` equals bits [29:0] of `desc_w0`, unchanged.
- R3: `res_sec[5:0]` equals the stored slice `{desc_w1[3:0], desc_w0[31:30]}`. The second word supplies the upper four slice bits and the first word supplies slice bits [1:0].
- R4: When slice bit 5 is 0, or bit 5 of `live_sec` is 1, `res_sec[47:6]` equals `live_sec[47:6]` as sampled on the same edge as the words.
- R5: When slice bit 5 is 1 and bit 5 of `live_sec` is 0, `res_sec` is the merged value minus 64. That is, `res_sec[47:6]` equals `live_sec[47:6] - 1`.
- R6: The subtraction in R5 wraps modulo 2^48. If `live_sec[47:6]` is zero, `res_sec[47:6]` becomes all ones.
- R7: A strobe with `stamp_present` at 0 produces no `res_vld`, and the result outputs keep their previous values.
- R8: Each strobe with `stamp_present` at 1 gives exactly one `res_vld` pulse, one cycle later. Strobes on consecutive cycles give results on consecutive cycles, in order.
- R9: While `res_vld` is 0, `res_sec` and `res_ns` do not change.
- R10: Bits [31:4] of `desc_w1` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_fire | input | 1 | One-cycle strobe presenting the descriptor words |
| stamp_present | input | 1 | Descriptor flag saying a stamp was captured |
| desc_w0 | input | 32 | First descriptor word: nanoseconds and low slice bits |
| desc_w1 | input | 32 | Second descriptor word: upper slice bits |
| live_sec | input | 48 | Running timer seconds |
| res_vld | output | 1 | Result valid pulse |
| res_sec | output | 48 | Rebuilt seconds |
| res_ns | output | 30 | Nanoseconds |

## Verification
A wrong wrap decision shows on the next `res_vld` pulse as upper seconds that are off by exactly one. Slice patterns are therefore chosen on both sides of bit 5, paired with live values whose bit 5 is set and whose bit 5 is clear. A swapped or misplaced slice field corrupts the low six bits of the same result. A corrupt valid path shows either as a pulse with no matching expectation, or as an expectation still unmet one cycle after its strobe.

// File: rtl/ts_rebuild_pkg.sv
package ts_rebuild_pkg;

  // A rollover happened when the stored slice's top bit is set
  // while the live counter's matching bit is already clear.
  function automatic logic slice_rolled(input logic slice_msb, input logic live_bit);
    return slice_msb && !live_bit;
  endfunction

endpackage

// File: rtl/ts_field_unpack.sv
module ts_field_unpack #(
  parameter int WORD_W = 32,
  parameter int NS_W   = 30,
  parameter int LO_W   = 2,
  parameter int HI_W   = 4,
  localparam int TRUNC_W = LO_W + HI_W
) (
  input  logic [WORD_W-1:0]  w0,
  input  logic [WORD_W-1:0]  w1,
  output logic [NS_W-1:0]    ns,
  output logic [TRUNC_W-1:0] slice
);

  assign ns = w0[NS_W-1:0];

  generate
    if (HI_W > 0) begin : g_two_words
      assign slice = {w1[HI_W-1:0], w0[NS_W +: LO_W]};
      logic unused_w1_hi;
      assign unused_w1_hi = ^w1[WORD_W-1:HI_W];
    end else begin : g_one_word
      assign slice = w0[NS_W +: LO_W];
      logic unused_w1_all;
      assign unused_w1_all = ^w1;
    end
    if (NS_W + LO_W < WORD_W) begin : g_w0_spare
      logic unused_w0_top;
      assign unused_w0_top = ^w0[WORD_W-1:NS_W+LO_W];
    end
  endgenerate

endmodule

// File: rtl/ts_sec_extend.sv
module ts_sec_extend
  import ts_rebuild_pkg::*;
#(
  parameter int SEC_W   = 48,
  parameter int TRUNC_W = 6,
  localparam int UP_W   = SEC_W - TRUNC_W
) (
  input  logic [TRUNC_W-1:0] slice,
  input  logic [SEC_W-1:0]   live,
  output logic [SEC_W-1:0]   full
);

  logic          rolled;
  logic [UP_W-1:0] upper;

  assign rolled = slice_rolled(slice[TRUNC_W-1], live[TRUNC_W-1]);
  // Dropping 2^TRUNC_W only touches the bits above the slice.
  assign upper  = live[SEC_W-1:TRUNC_W] - UP_W'(rolled);
  assign full   = {upper, slice};

  generate
    if (TRUNC_W > 1) begin : g_live_low
      logic unused_live_low;
      assign unused_live_low = ^live[TRUNC_W-2:0];
    end
  endgenerate

endmodule

// File: rtl/ts_sec_rebuild.sv
module ts_sec_rebuild #(
  parameter int WORD_W = 32,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int LO_W   = 2,
  parameter int HI_W   = 4,
  localparam int TRUNC_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_fire,
  input  logic              stamp_present,
  input  logic [WORD_W-1:0] desc_w0,
  input  logic [WORD_W-1:0] desc_w1,
  input  logic [SEC_W-1:0]  live_sec,
  output logic              res_vld,
  output logic [SEC_W-1:0]  res_sec,
  output logic [NS_W-1:0]   res_ns
);

  logic [NS_W-1:0]    ns_c;
  logic [TRUNC_W-1:0] slice_c;
  logic [SEC_W-1:0]   sec_c;
  logic               take;

  assign take = desc_fire && stamp_present;

  ts_field_unpack #(
    .WORD_W(WORD_W), .NS_W(NS_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_unpack (
    .w0(desc_w0), .w1(desc_w1), .ns(ns_c), .slice(slice_c)
  );

  ts_sec_extend #(
    .SEC_W(SEC_W), .TRUNC_W(TRUNC_W)
  ) u_extend (
    .slice(slice_c), .live(live_sec), .full(sec_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_sec <= '0;
      res_ns  <= '0;
    end else begin
      res_vld <= take;
      if (take) begin
        res_sec <= sec_c;
        res_ns  <= ns_c;
      end
    end
  end

endmodule

// File: rtl/ts_sec_rebuild_chk.sv
module ts_sec_rebuild_chk #(
  parameter int WORD_W = 32,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int LO_W   = 2,
  parameter int HI_W   = 4,
  localparam int TRUNC_W = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_fire,
  input logic              stamp_present,
  input logic [WORD_W-1:0] desc_w0,
  input logic [WORD_W-1:0] desc_w1,
  input logic [SEC_W-1:0]  live_sec,
  input logic              res_vld,
  input logic [SEC_W-1:0]  res_sec,
  input logic [NS_W-1:0]   res_ns
);

  logic [TRUNC_W-1:0] exp_slice;
  logic               exp_roll;
  assign exp_slice = {desc_w1[HI_W-1:0], desc_w0[NS_W +: LO_W]};
  assign exp_roll  = exp_slice[TRUNC_W-1] & ~live_sec[TRUNC_W-1];

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !res_vld);

  assert_ns_pass_R2: assert property (@(posedge clk) disable iff (rst)
    desc_fire && stamp_present |=> res_ns == $past(desc_w0[NS_W-1:0]));

  assert_slice_bits_R3: assert property (@(posedge clk) disable iff (rst)
    desc_fire && stamp_present |=> res_sec[TRUNC_W-1:0] == $past(exp_slice));

  assert_upper_live_R4: assert property (@(posedge clk) disable iff (rst)
    desc_fire && stamp_present && !exp_roll |=>
      res_sec[SEC_W-1:TRUNC_W] == $past(live_sec[SEC_W-1:TRUNC_W]));

  assert_roll_back_R5: assert property (@(posedge clk) disable iff (rst)
    desc_fire && stamp_present && exp_roll |=>
      res_sec[SEC_W-1:TRUNC_W] + 1'b1 == $past(live_sec[SEC_W-1:TRUNC_W]));

  assert_no_stamp_R7: assert property (@(posedge clk) disable iff (rst)
    !(desc_fire && stamp_present) |=> !res_vld);

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    desc_fire && stamp_present |=> res_vld);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> $stable(res_sec) && $stable(res_ns));

endmodule

bind ts_sec_rebuild ts_sec_rebuild_chk #(
  .WORD_W(WORD_W), .SEC_W(SEC_W), .NS_W(NS_W), .LO_W(LO_W), .HI_W(HI_W)
) u_chk (
  .clk(clk), .rst(rst), .desc_fire(desc_fire), .stamp_present(stamp_present),
  .desc_w0(desc_w0), .desc_w1(desc_w1), .live_sec(live_sec),
  .res_vld(res_vld), .res_sec(res_sec), .res_ns(res_ns)
);

// File: tb/tb_ts_sec_rebuild.sv
`timescale 1ns/1ps
module tb_ts_sec_rebuild;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_fire = 1'b0;
  logic        stamp_present = 1'b0;
  logic [31:0] desc_w0 = '0;
  logic [31:0] desc_w1 = '0;
  logic [47:0] live_sec = '0;
  logic        res_vld;
  logic [47:0] res_sec;
  logic [29:0] res_ns;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  logic [77:0] expq[$];
  logic [47:0] last_sec;
  logic [29:0] last_ns;

  always #2 clk = ~clk;

  ts_sec_rebuild dut (
    .clk(clk), .rst(rst), .desc_fire(desc_fire), .stamp_present(stamp_present),
    .desc_w0(desc_w0), .desc_w1(desc_w1), .live_sec(live_sec),
    .res_vld(res_vld), .res_sec(res_sec), .res_ns(res_ns)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected value from the requirements: merge upper live bits, then
  // take off 64 on a detected rollover, modulo 2^48.
  function automatic logic [47:0] model_sec(input logic [31:0] w0, input logic [31:0] w1,
                                            input logic [47:0] live);
    logic [5:0]  sl;
    logic [47:0] f;
    sl = {w1[3:0], w0[31:30]};
    f  = (live & ~48'h3F) | {42'b0, sl};
    if (sl[5] && !live[5]) f = f - 48'd64;
    return f;
  endfunction

  task automatic drive(input bit fire, input bit pres, input logic [31:0] w0,
                       input logic [31:0] w1, input logic [47:0] live);
    @(negedge clk);
    desc_fire     = fire;
    stamp_present = pres;
    desc_w0       = w0;
    desc_w1       = w1;
    live_sec      = live;
    if (fire && pres) expq.push_back({model_sec(w0, w1, live), w0[29:0]});
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 48'h1234_5678_9ABC);
  endtask

  // Monitor: results are sampled just after the edge that registers them.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (res_vld) begin
          if (expq.size() == 0) begin
            check(1'b0, "R7 unexpected res_vld", 64'(res_vld), 64'd0);
          end else begin
            logic [77:0] e;
            e = expq.pop_front();
            check(res_sec == e[77:30], "R3/R4/R5 res_sec", 64'(res_sec), 64'(e[77:30]));
            check(res_ns == e[29:0], "R2 res_ns", 64'(res_ns), 64'(e[29:0]));
          end
        end else begin
          check(expq.size() == 0, "R8 res_vld missing one cycle after strobe",
                64'(res_vld), 64'd1);
          check(res_sec == last_sec && res_ns == last_ns, "R9 outputs held",
                64'(res_sec), 64'(last_sec));
        end
        last_sec = res_sec;
        last_ns  = res_ns;
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(res_vld == 1'b0, "R1 res_vld after reset", 64'(res_vld), 64'd0);
    check(res_sec == 48'd0, "R1 res_sec after reset", 64'(res_sec), 64'd0);
    check(res_ns == 30'd0, "R1 res_ns after reset", 64'(res_ns), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    last_sec = res_sec;
    last_ns  = res_ns;
    mon_on = 1'b1;

    // R3/R4: slice bit 5 clear, no rollover
    drive(1, 1, {2'b10, 30'd123456789}, 32'h0000_0005, 48'h0000_1234_5680);
    idle();
    // R4: slice bit 5 set, live bit 5 set
    drive(1, 1, {2'b01, 30'd999_999_999}, 32'h0000_000D, 48'h0000_0000_00E0);
    idle();
    // R5: slice bit 5 set, live bit 5 clear -> roll back
    drive(1, 1, {2'b11, 30'd42}, 32'h0000_000F, 48'h0000_0ABC_0101);
    idle();
    // R6: roll back with zero upper bits wraps to all ones
    drive(1, 1, {2'b00, 30'd7}, 32'h0000_0008, 48'h0000_0000_0003);
    idle();
    // R10: junk above w1[3:0] is ignored
    drive(1, 1, {2'b10, 30'd555}, 32'hFFFF_FFF3, 48'h7777_0000_0040);
    idle();
    drive(1, 1, {2'b10, 30'd555}, 32'h0000_0003, 48'h7777_0000_0040);
    idle();
    // R7: strobe without stamp; outputs must hold
    drive(1, 0, {2'b11, 30'd1}, 32'h0000_0009, 48'hFFFF_FFFF_FFFF);
    idle();
    idle();
    // R8: back-to-back strobes, in order
    drive(1, 1, {2'b00, 30'd10}, 32'h0000_0001, 48'h0000_0000_1000);
    drive(1, 1, {2'b01, 30'd11}, 32'h0000_000A, 48'h0000_0000_1000);
    drive(1, 1, {2'b10, 30'd12}, 32'h0000_0004, 48'h0000_0000_1020);
    drive(0, 1, {2'b10, 30'd13}, 32'h0000_0004, 48'h0000_0000_1020);
    idle();
    // Mixed random traffic
    for (int i = 0; i < 300; i++) begin
      drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) != 0),
            $urandom(), $urandom(), {16'($urandom()), 32'($urandom())});
    end
    idle();
    idle();
    check(expq.size() == 0, "R8 all results delivered", 64'(expq.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule